// File: doc/BRIEF.md
# Indexed Palette RAM Controller

This block stores a 512-entry colour table, each entry 9 bits wide, and exposes it through a small byte-wide register port for a host CPU. The CPU loads a 9-bit table pointer through two byte registers. It then reads or writes entries through a low data byte and a high data byte. Any access to the high data byte, read or write, advances the pointer by one. A control register holds the display mode bits. The block decodes them into registered mode signals for downstream timing logic.

A second, independent port serves the pixel pipeline. It takes a 9-bit pixel index and returns the stored 9-bit colour one clock later. Slot 0 of every 16-entry sub-palette does not read its own entry. It mirrors a shared backdrop colour instead: entry 0 for the lower half of the table and entry 256 for the upper half.

After reset, a two-state controller (FILL, then RUN) first loads the power-up checkerboard pattern into the table, one entry per cycle. The only transition is FILL to RUN, taken on the cycle that writes entry 511. RUN is held until the next reset. CPU accesses are ignored while the controller is in FILL.

Top module: `pal_ram_ctl`

## Requirements
- R1: After reset, `init_done` is 0 and all mode outputs are 0. The controller stays in FILL for exactly 512 cycles, then raises `init_done` and keeps it high. While `init_done` is 0, CPU accesses change neither the table, the pointer nor the control register.
- R2: The fill writes each entry i with 0x000 when bit 0 of i XOR bit 3 of i is 1, and with 0x1FF otherwise.
- R3: A write to offset 2 loads pointer bits 7:0 and keeps bit 8. A write to offset 3 loads pointer bit 8 from data bit 0 and keeps bits 7:0.
- R4: A write to offset 4 replaces entry bits 7:0 and keeps bit 8. A write to offset 5 replaces bit 8 from data bit 0, keeps bits 7:0, and increments the pointer.
- R5: A read at offset 4 returns entry bits 7:0. A read at offset 5 returns entry bit 8 in bit 0 with bits 7:1 set to 1, and the pointer increments on that cycle's clock edge.
- R6: The pointer wraps from 511 to 0 on increment.
- R7: A lookup index whose low 4 bits are zero returns entry 0 if index bit 8 is 0, and entry 256 if it is 1. Any other index returns its own entry.
- R8: A write to offset 0 loads the control register. `dot_mode` is 2 when data bit 1 is set, and data bit 0 otherwise. `tall_frame` (263 lines) follows bit 2 and `grey_mode` follows bit 7.
- R9: A read at offsets 0, 1, 2, 3, 6 or 7 returns 0xFF.
- R10: `pix_color` is registered with one cycle of latency. A CPU write to an entry shows on `pix_color` one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | CPU access select |
| cpu_wr | input | 1 | Write strobe (takes precedence over read) |
| cpu_rd | input | 1 | Read strobe |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from offset and pointer |
| pix_idx | input | 9 | Pixel lookup index |
| pix_color | output | 9 | Looked-up colour (green 8:6, red 5:3, blue 2:0) |
| dot_mode | output | 2 | Dot-clock mode 0, 1 or 2 |
| tall_frame | output | 1 | 263-line frame selected |
| grey_mode | output | 1 | Colour-burst-stripped output selected |
| init_done | output | 1 | Table fill complete, CPU port live |

## Verification
The bench plants distinct marker colours in entries 0, 256 and 0x108. A pointer half-write that clobbered the other half, or a lookup that mirrored from the wrong half, would then return the checkerboard value instead of the marker. It reads across the 511-to-0 boundary; a pointer that saturated or grew a tenth bit would read entry 511 twice. It holds a lookup index steady while writing that entry to confirm the one-cycle visibility; a design that bypassed the write would show the new colour a cycle early. It also probes the high-byte read format and the unused offsets, where a design that left bits 7:1 clear would return 0x00 or 0x01 rather than 0xFE, 0xFF or 0xFF.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int ENTRIES = 512;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int COL_W   = 9;

    typedef enum logic [2:0] {
        OFF_CTRL  = 3'd0,
        OFF_PTR_L = 3'd2,
        OFF_PTR_H = 3'd3,
        OFF_DAT_L = 3'd4,
        OFF_DAT_H = 3'd5
    } pal_off_e;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } pal_state_e;

    function automatic logic [COL_W-1:0] boot_colour(input logic [IDX_W-1:0] i);
        return (i[0] ^ i[3]) ? '0 : '1;
    endfunction
endpackage

// File: rtl/pal_regs.sv
module pal_regs
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [2:0]       cpu_addr,
    input  logic [7:0]       cpu_wdata,
    output logic [IDX_W-1:0] tbl_addr,
    output logic [7:0]       ctrl
);
    logic step;

    always_comb begin
        step = acc_en && (cpu_addr == OFF_DAT_H) && (cpu_wr || cpu_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_addr <= '0;
            ctrl     <= '0;
        end else begin
            if (acc_en && cpu_wr) begin
                unique case (cpu_addr)
                    OFF_CTRL:  ctrl <= cpu_wdata;
                    OFF_PTR_L: tbl_addr[7:0] <= cpu_wdata;
                    OFF_PTR_H: tbl_addr[IDX_W-1] <= cpu_wdata[0];
                    default: ;
                endcase
            end
            if (step)
                tbl_addr <= tbl_addr + 1'b1;
        end
    end
endmodule

// File: rtl/pal_mem.sv
module pal_mem
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [COL_W-1:0] wdata,
    input  logic [IDX_W-1:0] cpu_raddr,
    output logic [COL_W-1:0] cpu_q,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [COL_W-1:0] pix_q
);
    logic [COL_W-1:0] store [ENTRIES];
    logic [IDX_W-1:0] eff_idx;

    always_comb begin
        cpu_q   = store[cpu_raddr];
        eff_idx = (pix_idx[3:0] == 4'h0) ? {pix_idx[IDX_W-1], {(IDX_W-1){1'b0}}} : pix_idx;
    end

    always_ff @(posedge clk) begin
        if (we)
            store[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pix_q <= '0;
        else
            pix_q <= store[eff_idx];
    end
endmodule

// File: rtl/pal_ram_ctl.sv
module pal_ram_ctl
    import pal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_sel,
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [2:0] cpu_addr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic [8:0] pix_idx,
    output logic [8:0] pix_color,
    output logic [1:0] dot_mode,
    output logic       tall_frame,
    output logic       grey_mode,
    output logic       init_done
);
    pal_state_e       state, state_nx;
    logic [IDX_W-1:0] fill_idx, fill_nx;
    logic [IDX_W-1:0] tbl_addr;
    logic [7:0]       ctrl;
    logic [COL_W-1:0] cpu_q;
    logic             acc_en;
    logic             mem_we;
    logic [IDX_W-1:0] mem_waddr;
    logic [COL_W-1:0] mem_wdata;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            fill_idx <= '0;
        end else begin
            state    <= state_nx;
            fill_idx <= fill_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx  = state;
        fill_nx   = fill_idx;
        acc_en    = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = tbl_addr;
        mem_wdata = cpu_q;
        unique case (state)
            ST_FILL: begin
                mem_we    = 1'b1;
                mem_waddr = fill_idx;
                mem_wdata = boot_colour(fill_idx);
                fill_nx   = fill_idx + 1'b1;
                if (fill_idx == IDX_W'(ENTRIES - 1))
                    state_nx = ST_RUN;
            end
            ST_RUN: begin
                acc_en = cpu_sel;
                if (cpu_sel && cpu_wr && cpu_addr == OFF_DAT_L) begin
                    mem_we    = 1'b1;
                    mem_wdata = {cpu_q[COL_W-1], cpu_wdata};
                end else if (cpu_sel && cpu_wr && cpu_addr == OFF_DAT_H) begin
                    mem_we    = 1'b1;
                    mem_wdata = {cpu_wdata[0], cpu_q[7:0]};
                end
            end
        endcase
    end

    always_comb begin
        init_done  = (state == ST_RUN);
        dot_mode   = ctrl[1] ? 2'd2 : {1'b0, ctrl[0]};
        tall_frame = ctrl[2];
        grey_mode  = ctrl[7];
        unique case (cpu_addr)
            OFF_DAT_L: cpu_rdata = cpu_q[7:0];
            OFF_DAT_H: cpu_rdata = {7'h7F, cpu_q[COL_W-1]};
            default:   cpu_rdata = 8'hFF;
        endcase
    end

    pal_regs u_regs (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .tbl_addr(tbl_addr), .ctrl(ctrl)
    );

    pal_mem u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .cpu_raddr(tbl_addr), .cpu_q(cpu_q), .pix_idx(pix_idx), .pix_q(pix_color)
    );
endmodule

// File: rtl/pal_ram_chk.sv
module pal_ram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_sel,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic [2:0] cpu_addr,
    input logic [7:0] cpu_wdata,
    input logic [7:0] cpu_rdata,
    input logic [8:0] tbl_addr,
    input logic [1:0] dot_mode,
    input logic       tall_frame,
    input logic       grey_mode,
    input logic       init_done
);
    a_r1_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r1_fill_ignores_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && $past(!init_done)) |-> tbl_addr == 9'd0 && dot_mode == 2'd0);

    a_r3_ptr_low: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cpu_sel && cpu_wr && cpu_addr == 3'd2)
        |=> tbl_addr == {$past(tbl_addr[8]), $past(cpu_wdata)});

    a_r3_ptr_high: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cpu_sel && cpu_wr && cpu_addr == 3'd3)
        |=> tbl_addr == {$past(cpu_wdata[0]), $past(tbl_addr[7:0])});

    a_r4_low_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cpu_sel && cpu_wr && cpu_addr == 3'd4) |=> $stable(tbl_addr));

    // R5 and R6: high-byte access steps the pointer, wrapping in 9 bits
    a_r5_high_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cpu_sel && (cpu_wr || cpu_rd) && cpu_addr == 3'd5)
        |=> tbl_addr == 9'($past(tbl_addr) + 9'd1));

    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cpu_sel && cpu_rd && !cpu_wr && cpu_addr == 3'd5 && tbl_addr == 9'h1FF)
        |=> tbl_addr == 9'd0);

    a_r5_high_format: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == 3'd5) |-> cpu_rdata[7:1] == 7'h7F);

    a_r8_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cpu_sel && cpu_wr && cpu_addr == 3'd0)
        |=> (dot_mode == ($past(cpu_wdata[1]) ? 2'd2 : {1'b0, $past(cpu_wdata[0])}))
            && tall_frame == $past(cpu_wdata[2]) && grey_mode == $past(cpu_wdata[7]));

    a_r9_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr != 3'd4 && cpu_addr != 3'd5) |-> cpu_rdata == 8'hFF);
endmodule

bind pal_ram_ctl pal_ram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .tbl_addr(tbl_addr), .dot_mode(dot_mode), .tall_frame(tall_frame),
    .grey_mode(grey_mode), .init_done(init_done)
);

// File: tb/pal_ram_ctl_test.sv
module pal_ram_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic [8:0] pix_idx = 9'd0;
    logic [8:0] pix_color;
    logic [1:0] dot_mode;
    logic       tall_frame, grey_mode, init_done;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    pal_ram_ctl uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pix_idx(pix_idx), .pix_color(pix_color), .dot_mode(dot_mode),
        .tall_frame(tall_frame), .grey_mode(grey_mode), .init_done(init_done)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = off; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [2:0] off, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_rd = 1'b1; cpu_addr = off;
        #2 d = cpu_rdata;
        @(posedge clk); #1;
        cpu_sel = 1'b0; cpu_rd = 1'b0;
    endtask

    task automatic set_ptr(input logic [8:0] a);
        cpu_write(3'd3, {7'd0, a[8]});
        cpu_write(3'd2, a[7:0]);
    endtask

    task automatic lookup(input logic [8:0] idx, output logic [8:0] c);
        @(negedge clk); pix_idx = idx;
        @(posedge clk); #1 c = pix_color;
    endtask

    task automatic t_reset_fill;
        logic [7:0] d;
        check("R1 init_done low", int'(init_done), 0);
        check("R1 dot_mode", int'(dot_mode), 0);
        check("R1 tall/grey", int'({tall_frame, grey_mode}), 0);
        cpu_write(3'd0, 8'h86);       // ignored during fill
        for (int i = 0; i < 520 && !init_done; i++) @(posedge clk);
        #1 check("R1 init_done high", int'(init_done), 1);
        check("R1 ctrl write ignored in fill", int'(dot_mode), 0);
        set_ptr(9'd0);
        cpu_read(3'd4, d); check("R2 entry0 low", d, 8'hFF);
        cpu_read(3'd5, d); check("R2 entry0 high", d, 8'hFF);
        cpu_read(3'd4, d); check("R2 entry1 low", d, 8'h00);
        cpu_read(3'd5, d); check("R5 entry1 high fmt", d, 8'hFE);
        cpu_read(3'd4, d); check("R5 incremented to entry2", d, 8'hFF);
    endtask

    task automatic t_ptr_halves;
        logic [7:0] d;
        set_ptr(9'h108);
        cpu_write(3'd4, 8'hA5);
        cpu_write(3'd5, 8'h00);     // entry 0x108 = 0x0A5, pointer -> 0x109
        cpu_write(3'd2, 8'h08);     // keeps bit 8 -> 0x108
        cpu_read(3'd4, d); check("R3 low write keeps bit8", d, 8'hA5);
        cpu_read(3'd5, d); check("R4 high write bit8", d, 8'hFE);
        cpu_write(3'd2, 8'h08);
        cpu_write(3'd3, 8'h00);     // keeps low -> 0x008
        cpu_read(3'd4, d); check("R3 high write keeps low", d, 8'h00);
    endtask

    task automatic t_mirror;
        logic [8:0] c;
        set_ptr(9'h000);
        cpu_write(3'd4, 8'h55);
        cpu_write(3'd5, 8'h01);     // entry0 = 0x155
        set_ptr(9'h100);
        cpu_write(3'd4, 8'h3C);     // entry256 low, bit8 kept (1) -> 0x13C
        lookup(9'h030, c); check("R7 low half mirror", c, 9'h155);
        lookup(9'h010, c); check("R7 slot16 mirror", c, 9'h155);
        lookup(9'h1F0, c); check("R7 high half mirror", c, 9'h13C);
        lookup(9'h031, c); check("R7 own entry", c, 9'h000);
        lookup(9'h101, c); check("R7 own entry upper", c, 9'h000);
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        set_ptr(9'h1FF);
        cpu_read(3'd5, d); check("R6 entry511 high", d, 8'hFF);
        cpu_read(3'd4, d); check("R6 wrapped to entry0", d, 8'h55);
    endtask

    task automatic t_latency;
        logic [8:0] c;
        set_ptr(9'h005);
        @(negedge clk); pix_idx = 9'h005;
        cpu_write(3'd4, 8'h12);
        check("R10 old value at write edge", int'(pix_color), 9'h000);
        @(posedge clk); #1 check("R10 new value one cycle later", int'(pix_color), 9'h012);
        cpu_write(3'd5, 8'h01);
        @(posedge clk); #1 check("R10 high byte visible", int'(pix_color), 9'h112);
        lookup(9'h005, c); check("R4 low kept on high write", c, 9'h112);
    endtask

    task automatic t_modes;
        cpu_write(3'd0, 8'h86);
        check("R8 dot_mode 2", int'(dot_mode), 2);
        check("R8 tall", int'(tall_frame), 1);
        check("R8 grey", int'(grey_mode), 1);
        cpu_write(3'd0, 8'h01);
        check("R8 dot_mode 1", int'(dot_mode), 1);
        check("R8 tall/grey off", int'({tall_frame, grey_mode}), 0);
        cpu_write(3'd0, 8'h03);
        check("R8 bit1 wins", int'(dot_mode), 2);
    endtask

    task automatic t_unused;
        logic [7:0] d;
        cpu_read(3'd0, d); check("R9 off0", d, 8'hFF);
        cpu_read(3'd1, d); check("R9 off1", d, 8'hFF);
        cpu_read(3'd6, d); check("R9 off6", d, 8'hFF);
        cpu_read(3'd7, d); check("R9 off7", d, 8'hFF);
    endtask

    initial begin
        #20 rst_n = 1'b1;
        #1;
        t_reset_fill();
        t_ptr_halves();
        t_mirror();
        t_wrap();
        t_latency();
        t_modes();
        t_unused();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule